// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static memory. It has a two-stage read pipeline and 36-bit words made of four 9-bit byte lanes. The depth is a parameter. An access starts when either of two address strobes captures an external address. Following cycles can then continue the access as a burst of up to four words. A 2-bit counter generates those addresses and wraps inside the aligned group of four. The counter steps only on cycles where the advance input is low. A mode input selects the beat order: linear (add the count modulo 4) or interleaved (XOR the count into the low two address bits).

Writes either touch only the lanes picked by the per-lane selects under a byte-write enable, or all four lanes under a global write enable. Three chip selects qualify every strobe. A deselect turns the outputs off on the same pipeline stage that read data uses, so the block behaves as a single-cycle deselect part. The output enable and the sleep input gate the output combinationally. Sleep also freezes every access while keeping the stored contents. The output has no tri-state pad. When the output is not driven, it reads as all zeros with a valid flag held low.

Top module: `sburst_sram`

## Requirements
- R1: The block is selected only when sel_a_n=0, sel_b=1 and sel_c_n=0. A lda_cpu_n strobe while not selected is ignored: no access begins, no write happens, and a running burst continues at its current address. A lda_ctl_n strobe while not selected is captured as a deselect.
- R2: A read is captured at clock edge k. Its word appears on dout with dout_valid=1 after edge k+1 and holds until edge k+2. Nothing from that read is visible after edge k.
- R3: A strobe may capture a new address on every cycle. Back-to-back strobed reads return one word per cycle, in address order.
- R4: With linear_seq=1, beat n of a burst that starts at address A reads {A[AW-1:2], (A[1:0]+n) mod 4}.
- R5: With linear_seq=0, beat n reads {A[AW-1:2], A[1:0] XOR n}. The low level, which is the tie-off default, therefore gives interleaved order.
- R6: A cycle that continues a burst steps the counter only when step_n=0. With step_n=1 the same word is accessed again. The counter wraps from 3 to 0.
- R7: With wbyte_n=0 and wall_n=1, lane i (din bits 9i+8:9i) is written only where lane_n[i]=0, and the other lanes keep their old value. If no lane is selected the cycle is a read.
- R8: wall_n=0 writes all four lanes whatever the values of wbyte_n and lane_n.
- R9: A deselect or a write captured at edge k leaves dout_valid=0 after edge k+1. A read captured at edge k-1 still appears after edge k.
- R10: oe_n=1 forces dout_valid=0 and dout=0 at once, without waiting for a clock.
- R11: doze=1 forces dout_valid=0 at once. While doze=1 no access or write happens, and the stored contents are kept for reads after wake-up.
- R12: dout is all zeros whenever dout_valid=0. After reset dout_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW | External word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| lda_cpu_n | input | 1 | Address strobe, ignored when not selected |
| lda_ctl_n | input | 1 | Address strobe, deselects when not selected |
| step_n | input | 1 | Burst advance, active low |
| linear_seq | input | 1 | 1 = linear burst order, 0 = interleaved |
| wall_n | input | 1 | Global write of all lanes, active low |
| wbyte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| doze | input | 1 | Sleep request, active high, asynchronous on the output |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not valid |
| dout_valid | output | 1 | Read data valid |

## Verification
The assertions assume that no strobe arrives while the internal reset is still held, so that every access they track comes from live state. They also assume that oe_n and doze change only between clock edges. The stimulus changes all inputs at the falling edge and keeps the block idle through reset and the reset-release window. In the read-latency property, the output enable and sleep are excluded as reasons for the output to be off, so asynchronous gating never reads as a timing fault.

// File: rtl/sburst_pkg.sv
`timescale 1ns/1ps
package sburst_pkg;
  localparam int LANES    = 4;
  localparam int LANE_W   = 9;
  localparam int WORD_W   = LANES * LANE_W;
  localparam int BURST_CW = 2;
endpackage

// File: rtl/sburst_ctrl.sv
`timescale 1ns/1ps
module sburst_ctrl
  import sburst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             lda_cpu_n,
  input  logic             lda_ctl_n,
  input  logic             step_n,
  input  logic             wall_n,
  input  logic             wbyte_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             doze,
  output logic             load,
  output logic             advance,
  output logic             access,
  output logic             is_wr,
  output logic             desel,
  output logic [LANES-1:0] wlanes
);
  logic chosen, awake, start, cont;
  logic active_q, active_d;

  always_comb begin
    chosen  = ~sel_a_n & sel_b & ~sel_c_n;
    awake   = ~doze;
    // A strobe starts an access only when selected (R1).
    start   = chosen & (~lda_cpu_n | ~lda_ctl_n);
    desel   = awake & ~lda_ctl_n & ~chosen;
    cont    = active_q & ~start & ~desel;
    access  = awake & (start | cont);
    load    = awake & start;
    advance = awake & cont & ~step_n;
    // Global write overrides lane selects (R8), else byte lanes (R7).
    if (!wall_n)       wlanes = '1;
    else if (!wbyte_n) wlanes = ~lane_n;
    else               wlanes = '0;
    is_wr   = access & (|wlanes);
    active_d = active_q;
    if (load)       active_d = 1'b1;
    else if (desel) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end
endmodule

// File: rtl/sburst_addr.sv
`timescale 1ns/1ps
module sburst_addr
  import sburst_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic          advance,
  input  logic          linear_seq,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0]       base_q, base_d;
  logic [BURST_CW-1:0] cnt_q, cnt_d, low;
  logic                upd;

  always_comb begin
    base_d = load ? ext_addr : base_q;
    if (load)         cnt_d = '0;
    else if (advance) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
    // Linear adds modulo 4 (R4); interleaved XORs (R5).
    if (linear_seq) low = base_d[BURST_CW-1:0] + cnt_d;
    else            low = base_d[BURST_CW-1:0] ^ cnt_d;
    eff_addr = {base_d[AW-1:BURST_CW], low};
    upd      = load | advance;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sburst_array.sv
`timescale 1ns/1ps
module sburst_array
  import sburst_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [LANES-1:0]  wlanes,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_go,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] q;
    logic              wen;

    always_comb wen = we & wlanes[g];

    always_ff @(posedge clk) begin
      if (wen) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (rd_go) q <= store[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/sburst_outpipe.sv
`timescale 1ns/1ps
module sburst_outpipe
  import sburst_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              doze,
  input  logic              oe_n,
  input  logic              rd_cmd,
  input  logic [AW-1:0]     eff_addr,
  input  logic [WORD_W-1:0] rdata,
  output logic              rd_go,
  output logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);
  logic          pend_q, pend_d;
  logic          vld_q, vld_d;
  logic [AW-1:0] raddr_q, raddr_d;

  always_comb begin
    pend_d  = rd_cmd;
    raddr_d = rd_cmd ? eff_addr : raddr_q;
    vld_d   = pend_q & ~doze;
    rd_go   = pend_q & ~doze;
    raddr   = raddr_q;
    // Asynchronous gating by output enable and sleep (R10, R11).
    dout_valid = vld_q & ~oe_n & ~doze;
    dout       = dout_valid ? rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
      raddr_q <= '0;
    end else begin
      pend_q  <= pend_d;
      vld_q   <= vld_d;
      raddr_q <= raddr_d;
    end
  end
endmodule

// File: rtl/sburst_sram.sv
`timescale 1ns/1ps
module sburst_sram
  import sburst_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              lda_cpu_n,
  input  logic              lda_ctl_n,
  input  logic              step_n,
  input  logic              linear_seq,
  input  logic              wall_n,
  input  logic              wbyte_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              oe_n,
  input  logic              doze,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);
  logic [1:0]        rs_q;
  logic              rst_q_n;
  logic              load, advance, access, is_wr, desel, rd_cmd, rd_go;
  logic [LANES-1:0]  wlanes;
  logic [AW-1:0]     eff_addr, raddr;
  logic [WORD_W-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  sburst_ctrl u_ctrl (
    .clk(clk), .rst_ni(rst_q_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .lda_cpu_n(lda_cpu_n), .lda_ctl_n(lda_ctl_n), .step_n(step_n),
    .wall_n(wall_n), .wbyte_n(wbyte_n), .lane_n(lane_n), .doze(doze),
    .load(load), .advance(advance), .access(access), .is_wr(is_wr),
    .desel(desel), .wlanes(wlanes)
  );

  sburst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_ni(rst_q_n), .load(load), .advance(advance),
    .linear_seq(linear_seq), .ext_addr(addr), .eff_addr(eff_addr)
  );

  assign rd_cmd = access & ~is_wr;

  sburst_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst_ni(rst_q_n), .we(is_wr), .waddr(eff_addr),
    .wlanes(wlanes), .wdata(din), .rd_go(rd_go), .raddr(raddr),
    .rdata(rdata)
  );

  sburst_outpipe #(.AW(AW)) u_out (
    .clk(clk), .rst_ni(rst_q_n), .doze(doze), .oe_n(oe_n),
    .rd_cmd(rd_cmd), .eff_addr(eff_addr), .rdata(rdata),
    .rd_go(rd_go), .raddr(raddr), .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/sburst_sram_chk.sv
`timescale 1ns/1ps
module sburst_sram_chk
  import sburst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              lda_ctl_n,
  input logic              doze,
  input logic              oe_n,
  input logic [WORD_W-1:0] dout,
  input logic              dout_valid,
  input logic              access,
  input logic              is_wr
);
  logic chosen;
  assign chosen = ~sel_a_n & sel_b & ~sel_c_n;

  a_r9_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!lda_ctl_n && !chosen && !doze) |=> ##1 !dout_valid);

  a_r9_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> ##1 !dout_valid);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(access && !is_wr, 2) && !$past(doze)) |-> (dout_valid || oe_n || doze));

  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_valid);

  a_r11_no_write_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    doze |-> (!is_wr && !access));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0));
endmodule

bind sburst_sram sburst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .lda_ctl_n(lda_ctl_n), .doze(doze), .oe_n(oe_n),
  .dout(dout), .dout_valid(dout_valid), .access(access), .is_wr(is_wr)
);

// File: tb/sburst_sram_test.sv
`timescale 1ns/1ps
module sburst_sram_test;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int W     = 36;

  logic clk, rst_n;
  logic [AW-1:0] addr;
  logic sel_a_n, sel_b, sel_c_n, lda_cpu_n, lda_ctl_n, step_n, linear_seq;
  logic wall_n, wbyte_n, oe_n, doze;
  logic [3:0] lane_n;
  logic [W-1:0] din, dout;
  logic dout_valid;

  logic [W-1:0] ref_mem [DEPTH];
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  sburst_sram #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .lda_cpu_n(lda_cpu_n), .lda_ctl_n(lda_ctl_n),
    .step_n(step_n), .linear_seq(linear_seq), .wall_n(wall_n),
    .wbyte_n(wbyte_n), .lane_n(lane_n), .oe_n(oe_n), .doze(doze),
    .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] pat(int a, int s);
    logic [W-1:0] x;
    x = 36'(a) * 36'd40503 + 36'(s) * 36'd77777;
    return x ^ 36'hA5A5A5A5A;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    lda_cpu_n = 1; lda_ctl_n = 1; step_n = 1;
    wall_n = 1; wbyte_n = 1; lane_n = 4'hF;
    doze = 0; oe_n = 0; din = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic desel();
    idle_in(); sel_a_n = 1; lda_ctl_n = 0;
    tick();
    idle_in();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [W-1:0] nw;
    logic [W-1:0] e;
    int beat_seq [6];
    rst_n = 0; addr = '0; linear_seq = 0;
    idle_in();
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    // R12 reset state
    check("R12 reset valid", W'(dout_valid), '0);
    check("R12 reset data", dout, '0);

    // Fill all words with global writes; lane controls vary (R8)
    for (int a = 0; a < DEPTH; a++) begin
      idle_in(); addr = AW'(a);
      lda_ctl_n = a[0]; lda_cpu_n = ~a[0];
      wall_n = 0; wbyte_n = a[1]; lane_n = a[3:0];
      din = pat(a, 1); ref_mem[a] = din;
      tick();
    end
    desel();
    check("R9 no output after writes", W'(dout_valid), '0);

    // Back-to-back strobed reads (R3, R8)
    for (int a = 0; a <= DEPTH; a++) begin
      idle_in();
      if (a < DEPTH) begin addr = AW'(a); lda_cpu_n = 0; end
      tick();
      if (a >= 1) begin
        check("R3 sweep valid", W'(dout_valid), W'(1));
        check("R8 sweep data", dout, ref_mem[a-1]);
      end
    end
    desel();
    check("R9 prior read survives deselect", dout, ref_mem[DEPTH-1]);
    tick();
    check("R9 off after deselect", W'(dout_valid), '0);

    // Single read latency (R2)
    idle_in(); addr = 30; lda_ctl_n = 0;
    tick();
    check("R2 not yet valid", W'(dout_valid), '0);
    desel();
    check("R2 data one stage later", dout, ref_mem[30]);
    tick();

    // Bursts in both orders (R4, R5)
    for (int mode = 0; mode < 2; mode++) begin
      for (int s = 0; s < 4; s++) begin
        int g;
        g = 32 + 4 * s;
        linear_seq = mode[0];
        for (int n = 0; n <= 4; n++) begin
          idle_in();
          if (n == 0) begin addr = AW'(g + s); lda_ctl_n = 0; end
          else if (n < 4) step_n = 0;
          else begin sel_a_n = 1; lda_ctl_n = 0; end
          tick();
          if (n >= 1) begin
            if (mode == 1) e = ref_mem[g + ((s + n - 1) & 3)];
            else           e = ref_mem[g + (s ^ (n - 1))];
            if (mode == 1) check("R4 linear beat", dout, e);
            else           check("R5 interleaved beat", dout, e);
          end
        end
        idle_in();
        tick();
        check("R9 burst ends off", W'(dout_valid), '0);
      end
    end

    // Advance hold and wrap (R6)
    linear_seq = 1;
    beat_seq = '{49, 49, 49, 50, 51, 48};
    for (int n = 0; n <= 6; n++) begin
      idle_in();
      if (n == 0) begin addr = 49; lda_ctl_n = 0; end
      else if (n == 1 || n == 2) step_n = 1;
      else if (n < 6) step_n = 0;
      else begin sel_a_n = 1; lda_ctl_n = 0; end
      tick();
      if (n >= 1) check("R6 advance hold", dout, ref_mem[beat_seq[n-1]]);
    end
    idle_in(); tick();

    // Byte writes, every lane mask (R7)
    for (int m = 0; m < 16; m++) begin
      idle_in(); addr = 10; lda_ctl_n = 0; wbyte_n = 0;
      lane_n = ~4'(m); nw = pat(10, m + 2); din = nw;
      for (int l = 0; l < 4; l++)
        if (m[l]) ref_mem[10][l*9 +: 9] = nw[l*9 +: 9];
      tick();
      idle_in(); addr = 10; lda_cpu_n = 0;
      tick();
      idle_in();
      tick();
      check("R7 byte lanes", dout, ref_mem[10]);
      desel();
    end
    tick();

    // Global write with all lane selects off (R8)
    idle_in(); addr = 12; lda_ctl_n = 0; wall_n = 0; wbyte_n = 0;
    din = pat(12, 99); ref_mem[12] = din;
    tick();
    idle_in(); addr = 12; lda_ctl_n = 0;
    tick(); idle_in(); tick();
    check("R8 global override", dout, ref_mem[12]);
    desel(); tick();

    // Ignored strobe during a burst (R1)
    idle_in(); addr = 40; lda_ctl_n = 0;
    tick();
    idle_in(); sel_b = 0; lda_cpu_n = 0; addr = 50;
    tick();
    check("R1 first word", dout, ref_mem[40]);
    idle_in();
    tick();
    check("R1 burst kept address", dout, ref_mem[40]);
    desel(); tick();

    // Ignored unselected write while idle (R1)
    idle_in(); sel_c_n = 1; lda_cpu_n = 0; wall_n = 0; addr = 5; din = ~ref_mem[5];
    tick(); idle_in(); tick();
    check("R1 no access unselected", W'(dout_valid), '0);
    idle_in(); addr = 5; lda_ctl_n = 0;
    tick(); desel();
    check("R1 no write unselected", dout, ref_mem[5]);
    tick();

    // Each failing select pattern deselects on the controller strobe (R1)
    for (int c = 0; c < 3; c++) begin
      idle_in(); addr = 3; lda_ctl_n = 0;
      tick();
      idle_in(); lda_ctl_n = 0;
      if (c == 0) sel_a_n = 1; else if (c == 1) sel_b = 0; else sel_c_n = 1;
      tick();
      check("R1 read before deselect", dout, ref_mem[3]);
      idle_in();
      tick();
      check("R1 deselected", W'(dout_valid), '0);
    end

    // Output enable (R10)
    idle_in(); addr = 21; lda_ctl_n = 0;
    tick(); idle_in(); tick();
    oe_n = 1; #1;
    check("R10 oe valid", W'(dout_valid), '0);
    check("R10 oe data", dout, '0);
    oe_n = 0; #1;
    check("R10 oe restore", dout, ref_mem[21]);
    desel(); tick();

    // Sleep (R11)
    idle_in(); addr = 20; lda_ctl_n = 0;
    tick(); idle_in(); tick();
    doze = 1; #1;
    check("R11 doze valid", W'(dout_valid), '0);
    check("R11 doze data", dout, '0);
    addr = 20; lda_ctl_n = 0; wall_n = 0; din = ~ref_mem[20];
    tick(); tick();
    check("R11 still off", W'(dout_valid), '0);
    idle_in(); addr = 20; lda_ctl_n = 0;
    tick(); idle_in(); tick();
    check("R11 contents kept", dout, ref_mem[20]);
    desel(); tick();

    done = 1;
    summary();
  end
endmodule